// File: doc/BRIEF.md
# Fixed-Window Peripheral Select Decoder

This block turns an 8-bit address into one of eight active-low chip selects. A single eight-byte window is served: addresses 0xA0 to 0xA7. Gating on the five upper address bits produces three enable terms. These terms drive a 3-to-8 decoder whose enables have mixed polarity: one enable is active high and two are active low. The three lowest address bits then pick which select goes low.

The block is purely combinational. An active-high global enable can switch the whole decoder off. A hit flag reports that one of the selects is currently asserted. A bus master places the address and enable on the inputs, and the addressed peripheral sees its select within the same cycle.

Top module: `periph_win_dec`

## Requirements
- R1: The active-high decoder enable is true only when address bit 7 and address bit 5 are both 1 (and the global enable is 1).
- R2: The first active-low decoder enable is the OR of address bits 6 and 4. Decoding happens only when both of these bits are 0.
- R3: The second active-low decoder enable follows address bit 3. Decoding happens only when bit 3 is 0.
- R4: When decoding, address bits [2:0] give the index of the select that is driven low. The value 000 drives sel_n_o[0], and 111 drives sel_n_o[7].
- R5: Selects are active low. When any enable condition fails, all eight select bits are 1.
- R6: A select goes low only for addresses 0xA0 through 0xA7 inclusive, and it does so for every address in that range.
- R7: hit_o is 1 exactly when en_i is 1 and the address lies in 0xA0 to 0xA7.
- R8: At no time is more than one select bit low.
- R9: With en_i at 0, every select bit is 1 and hit_o is 0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 8 | Bus address |
| en_i | input | 1 | Global enable, active high |
| sel_n_o | output | 8 | Peripheral selects, active low, bit index = addr_i[2:0] |
| hit_o | output | 1 | High when a select is asserted |

## Verification
A wrong gate polarity in the qualifier shows up as a select firing for a mirror window, for example 0xB0 or 0xE8, or as the real window staying silent. An index error shows up as the wrong bit going low for an in-window address. Because there is no state, every such fault is visible at the ports in the same cycle as the offending address. An exhaustive sweep of all 256 addresses, with the enable both on and off, therefore exposes it on the first address that triggers it.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  localparam int ADDR_W = 8;
  localparam int SEL_W  = 3;
  localparam int OUT_N  = 1 << SEL_W;

  // upper-bit positions that qualify the window
  localparam int HI_A  = 7;
  localparam int HI_B  = 5;
  localparam int LO_A  = 6;
  localparam int LO_B  = 4;
  localparam int AUX_B = 3;

  typedef struct packed {
    logic act_hi;   // active-high enable
    logic blk_n;    // active-low enable, OR of two bits
    logic aux_n;    // active-low enable, single bit
  } dec_en_t;
endpackage

// File: rtl/pdec_qualify.sv
module pdec_qualify
  import pdec_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          glb_en,
  output dec_en_t       en_o
);
  always_comb begin
    en_o.act_hi = glb_en & addr[HI_A] & addr[HI_B];
    en_o.blk_n  = addr[LO_A] | addr[LO_B];
    en_o.aux_n  = addr[AUX_B];
  end

  // R6: all three enables passing implies upper bits pattern 10100
  always_comb begin
    if (en_o.act_hi && !en_o.blk_n && !en_o.aux_n)
      win_pattern_chk: assert (addr[AW-1:SEL_W] == 5'b10100)
        else $error("qualifier passed outside window");
  end

  // R9: global enable off never passes the high enable
  always_comb begin
    if (!glb_en)
      glb_off_chk: assert (!en_o.act_hi) else $error("enable leaked");
  end
endmodule

// File: rtl/pdec_dec3to8.sv
module pdec_dec3to8
  import pdec_pkg::*;
#(
  parameter int SW = SEL_W,
  localparam int N = 1 << SW
) (
  input  logic [SW-1:0] idx,
  input  dec_en_t       en,
  output logic [N-1:0]  y_n
);
  logic active;
  assign active = en.act_hi & ~en.blk_n & ~en.aux_n;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign y_n[i] = ~(active && (idx == SW'(i)));
  end

  // R8
  always_comb begin
    one_low_chk: assert ($onehot0(~y_n)) else $error("multiple selects low");
  end

  // R5
  always_comb begin
    if (!en.act_hi || en.blk_n || en.aux_n)
      idle_high_chk: assert (&y_n) else $error("select low while disabled");
  end
endmodule

// File: rtl/periph_win_dec.sv
module periph_win_dec
  import pdec_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic [OUT_N-1:0]  sel_n_o,
  output logic              hit_o
);
  dec_en_t en_w;

  pdec_qualify #(.AW(ADDR_W)) u_qual (
    .addr   (addr_i),
    .glb_en (en_i),
    .en_o   (en_w)
  );

  pdec_dec3to8 #(.SW(SEL_W)) u_dec (
    .idx (addr_i[SEL_W-1:0]),
    .en  (en_w),
    .y_n (sel_n_o)
  );

  assign hit_o = ~&sel_n_o;

  // R7
  always_comb begin
    if (hit_o)
      hit_range_chk: assert (en_i && addr_i >= 8'hA0 && addr_i <= 8'hA7)
        else $error("hit outside window");
  end

  // R4
  always_comb begin
    if (hit_o)
      idx_line_chk: assert (!sel_n_o[addr_i[SEL_W-1:0]])
        else $error("wrong select line");
  end
endmodule

// File: tb/periph_win_dec_test.sv
module periph_win_dec_test;
  logic       clk = 1'b0;
  logic [7:0] addr;
  logic       en;
  logic [7:0] sel_n;
  logic       hit;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [7:0] a;
    logic       e;
    logic [7:0] sel;
    logic       h;
  } item_t;
  item_t sb[$];

  periph_win_dec uut (
    .addr_i  (addr),
    .en_i    (en),
    .sel_n_o (sel_n),
    .hit_o   (hit)
  );

  always #2.5 clk = ~clk;

  function automatic string tag_for(logic [7:0] a, logic e);
    if (!e) return "R9";
    if (!(a[7] && a[5])) return "R1";
    if (a[6] || a[4]) return "R2";
    if (a[3]) return "R3";
    return "R4";
  endfunction

  task automatic drive(input logic [7:0] a, input logic e);
    item_t it;
    logic  inwin;
    @(posedge clk);
    #1;
    addr = a;
    en   = e;
    inwin = (a >= 8'hA0) && (a <= 8'hA7);
    it.a   = a;
    it.e   = e;
    it.h   = e && inwin;
    it.sel = it.h ? ~(8'h01 << a[2:0]) : 8'hFF;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (sel_n !== it.sel) begin
        fails++;
        $display("FAIL %s/R5/R6 addr=%02h en=%0b sel actual=%02h expected=%02h",
                 tag_for(it.a, it.e), it.a, it.e, sel_n, it.sel);
      end
      checks++;
      if (hit !== it.h) begin
        fails++;
        $display("FAIL R7 addr=%02h en=%0b hit actual=%0b expected=%0b",
                 it.a, it.e, hit, it.h);
      end
      checks++;
      if ($countones(~sel_n) > 1) begin
        fails++;
        $display("FAIL R8 addr=%02h low count actual=%0d expected<=1",
                 it.a, $countones(~sel_n));
      end
    end
  end

  initial begin
    addr = 8'h00;
    en   = 1'b0;
    // idle state: enable off, all selects high (R9)
    #1;
    checks++;
    if (sel_n !== 8'hFF || hit !== 1'b0) begin
      fails++;
      $display("FAIL R9 idle sel actual=%02h expected=ff hit actual=%0b expected=0",
               sel_n, hit);
    end
    // full sweep, enable on then off (R1..R9)
    for (int e = 1; e >= 0; e--)
      for (int a = 0; a < 256; a++)
        drive(8'(a), e[0]);
    // window edges revisited (R6)
    drive(8'h9F, 1'b1);
    drive(8'hA0, 1'b1);
    drive(8'hA7, 1'b1);
    drive(8'hA8, 1'b1);
    drive(8'hA3, 1'b0);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  // watchdog and summary
  initial begin
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d cycles expected<5000", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule